// File: doc/BRIEF.md
# Converter Command Slave for a Two-Wire Bus

This block is the bus-facing controller of a 12-bit sampling converter. It sits on the two-wire serial bus as a slave, sampling SCL and SDA with the system clock through a synchroniser. It recognises start, repeated-start and stop conditions, decodes a 7-bit address built from a fixed prefix and two strap inputs, and accepts a one-byte command. From that traffic it produces single-cycle strobes that start and stop the converter and clear its result stack. It returns each 12-bit result to the master as two bytes.

The block also recognises the high-speed master code and keeps a mode flag for as long as the high-speed phase lasts. In that mode an external hold request can stretch SCL after a command, until a conversion is ready. The pad drivers are outside the block. Each line is driven by an active-low enable: 0 pulls the line low and 1 releases it.

Top module: `adc_i2c_cmd_slave`

## Requirements
- R1: The slave acknowledges (drives SDA low during the ninth clock) an address byte whose top seven bits equal 1,0,0,1,0 followed by the two strap bits (strapIn[1] then strapIn[0]). Bit 0 of the byte selects read (1) or write (0). Any other address is left unacknowledged, and the slave does not drive the bus for the rest of that transfer.
- R2: The strap value is taken on the first clock after reset is released. Later changes on strapIn do not alter the address.
- R3: After a matching write address, a command byte whose bits 7..5 are all 0 is acknowledged. Bits 4..0 are ignored.
- R4: convStart pulses for one cycle as soon as the third command bit (bit 5) has been sampled, provided bits 7, 6 and 5 are all 0. It fires before the byte completes.
- R5: A command byte with any of bits 7..5 set is not acknowledged, raises no convStart, and pulses stackClear once.
- R6: A valid command that follows a valid command, with no stop or read address between them, is not acknowledged and raises no convStart. convStop pulses once after the ninth clock of that byte.
- R7: In a read, each result word is sent MSB first as two bytes, {0000, D11..D8} and then D7..D0. popStrobe pulses once per word, during the master's acknowledge bit of the second byte.
- R8: A master NACK ends the read. From then on the slave leaves SDA released.
- R9: A matching read address ends a running conversion with one convStop pulse.
- R10: A stop condition ends a running conversion with one convStop pulse and clears hsMode.
- R11: A byte of the form 00001xxx right after a start condition is not acknowledged and sets hsMode. hsMode stays set through repeated starts.
- R12: In high-speed mode, after an acknowledged command byte, sclOeN is held low for as long as holdReq is high. sclOeN is never low outside high-speed mode.
- R13: After reset, sdaOeN and sclOeN are 1, hsMode is 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| strapIn | input | 2 | Address strap bits, captured after reset |
| holdReq | input | 1 | Request to stretch SCL in high-speed mode |
| rdData | input | 12 | Result word at the top of the stack |
| sclOeN | output | 1 | SCL drive enable, 0 pulls low |
| sdaOeN | output | 1 | SDA drive enable, 0 pulls low |
| hsMode | output | 1 | High-speed mode flag |
| convStart | output | 1 | One-cycle conversion start strobe |
| convStop | output | 1 | One-cycle conversion stop strobe |
| stackClear | output | 1 | One-cycle result stack clear strobe |
| popStrobe | output | 1 | One-cycle strobe taking the next word |

## Verification
A bit counter that is off by one shows within a single byte. The acknowledge lands on the wrong clock, or read data comes out shifted, on the very next SDA sample. A command-tracking flag left stale shows on the next command byte, either as a missing convStart or as a wrong acknowledge. A mode flag that is not cleared shows as hsMode still high, or as SCL still stretched, one clock after the stop or after holdReq falls. Stack sequencing errors show as a wrong popStrobe count, or as the wrong word, at the byte that follows.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
  localparam int BYTE_W = 8;

  // Bus events seen by the control, produced by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startCond;
    logic stopCond;
    logic sda;
  } busEv_t;

  // Strobes from control to the transmit shifter
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic shift;
  } txCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_ACKWAIT, ST_ACKHOLD,
    ST_TXBIT, ST_MACK, ST_MACKEND, ST_IGNORE
  } state_t;

  typedef enum logic [1:0] {AF_CMD, AF_TX, AF_IGN} after_t;
endpackage

// File: rtl/adc_i2c_datapath.sv
module adc_i2c_datapath
  import adc_i2c_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rdData,
  input  txCtl_t            txCtl,
  output busEv_t            busEv,
  output logic [BYTE_W-1:0] rxNext,
  output logic              txBit
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] rxReg, txReg;

  // Synchroniser chain: one flop per stage
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else if (g == 0) begin
          sclSync[g] <= sclIn;
          sdaSync[g] <= sdaIn;
        end else begin
          sclSync[g] <= sclSync[(g == 0) ? 0 : g-1];
          sdaSync[g] <= sdaSync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    busEv.sclRise   = sclS & ~sclD;
    busEv.sclFall   = ~sclS & sclD;
    busEv.startCond = sclS & sclD & sdaD & ~sdaS;
    busEv.stopCond  = sclS & sclD & ~sdaD & sdaS;
    busEv.sda       = sdaS;
  end

  // Receive shifter, sampled on SCL rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxReg <= '0;
    else if (busEv.sclRise) rxReg <= {rxReg[BYTE_W-2:0], sdaS};
  end
  assign rxNext = {rxReg[BYTE_W-2:0], sdaS};

  // Transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReg <= '1;
    else if (txCtl.loadHi) txReg <= BYTE_W'(rdData[DATA_W-1:BYTE_W]);
    else if (txCtl.loadLo) txReg <= rdData[BYTE_W-1:0];
    else if (txCtl.shift)  txReg <= {txReg[BYTE_W-2:0], 1'b1};
  end
  assign txBit = txReg[BYTE_W-1];

  if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_width
    initial $display("adc_i2c_datapath: DATA_W out of range");
  end
endmodule

// File: rtl/adc_i2c_ctrl.sv
module adc_i2c_ctrl
  import adc_i2c_pkg::*;
#(
  parameter logic [4:0] PREFIX = 5'b10010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        strapIn,
  input  logic              holdReq,
  input  busEv_t            busEv,
  input  logic [BYTE_W-1:0] rxNext,
  input  logic              txBit,
  output txCtl_t            txCtl,
  output logic              sdaOeN,
  output logic              sclOeN,
  output logic              hsMode,
  output logic              convStart,
  output logic              convStop,
  output logic              stackClear,
  output logic              popStrobe
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);
  localparam logic [2:0] CMD_CHK_BIT = 3'd2;  // third bit received = bit 5
  localparam logic [4:0] HS_CODE = 5'b00001;

  state_t state;
  after_t afterAck;
  logic [2:0] bitCnt;
  logic [1:0] strapQ;
  logic strapLoaded, ackDrv, pendStop, lastWasCmd, isLoByte, mAck;
  logic cmdSeen, convActive, stretchArm;

  always_comb begin
    txCtl = '0;
    if (busEv.sclFall) begin
      if (state == ST_ACKHOLD && afterAck == AF_TX) txCtl.loadHi = 1'b1;
      if (state == ST_TXBIT && bitCnt != LAST_BIT)  txCtl.shift  = 1'b1;
      if (state == ST_MACKEND && mAck) begin
        if (isLoByte) txCtl.loadHi = 1'b1;
        else          txCtl.loadLo = 1'b1;
      end
    end
  end

  assign sdaOeN = ~((state == ST_ACKHOLD && ackDrv) || (state == ST_TXBIT && !txBit));
  assign sclOeN = ~(stretchArm && holdReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      afterAck    <= AF_IGN;
      bitCnt      <= '0;
      strapQ      <= '0;
      strapLoaded <= 1'b0;
      ackDrv      <= 1'b0;
      pendStop    <= 1'b0;
      lastWasCmd  <= 1'b0;
      isLoByte    <= 1'b0;
      mAck        <= 1'b0;
      cmdSeen     <= 1'b0;
      convActive  <= 1'b0;
      stretchArm  <= 1'b0;
      hsMode      <= 1'b0;
      convStart   <= 1'b0;
      convStop    <= 1'b0;
      stackClear  <= 1'b0;
      popStrobe   <= 1'b0;
    end else begin
      convStart  <= 1'b0;
      convStop   <= 1'b0;
      stackClear <= 1'b0;
      popStrobe  <= 1'b0;

      if (!strapLoaded) begin
        strapQ      <= strapIn;
        strapLoaded <= 1'b1;
      end

      if (stretchArm && (!holdReq || busEv.sclRise)) stretchArm <= 1'b0;

      if (busEv.stopCond) begin
        state      <= ST_IDLE;
        hsMode     <= 1'b0;
        cmdSeen    <= 1'b0;
        stretchArm <= 1'b0;
        if (convActive) begin
          convStop   <= 1'b1;
          convActive <= 1'b0;
        end
      end else if (busEv.startCond) begin
        state      <= ST_ADDR;
        bitCnt     <= '0;
        stretchArm <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (busEv.sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == LAST_BIT) begin
              lastWasCmd <= 1'b0;
              pendStop   <= 1'b0;
              if (rxNext[7:3] == HS_CODE) begin
                hsMode <= 1'b1;
                state  <= ST_IGNORE;
              end else if (rxNext[7:1] == {PREFIX, strapQ}) begin
                ackDrv <= 1'b1;
                state  <= ST_ACKWAIT;
                if (rxNext[0]) begin
                  afterAck <= AF_TX;
                  cmdSeen  <= 1'b0;
                  if (convActive) begin
                    convStop   <= 1'b1;
                    convActive <= 1'b0;
                  end
                end else begin
                  afterAck <= AF_CMD;
                end
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_CMD: if (busEv.sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == CMD_CHK_BIT && rxNext[2:0] == 3'b000 && !cmdSeen) begin
              convStart  <= 1'b1;
              convActive <= 1'b1;
            end
            if (bitCnt == LAST_BIT) begin
              state      <= ST_ACKWAIT;
              lastWasCmd <= 1'b1;
              if (rxNext[7:5] != 3'b000) begin
                ackDrv     <= 1'b0;
                afterAck   <= AF_IGN;
                stackClear <= 1'b1;
                pendStop   <= convActive;
              end else if (cmdSeen) begin
                ackDrv   <= 1'b0;
                afterAck <= AF_IGN;
                pendStop <= 1'b1;
              end else begin
                ackDrv   <= 1'b1;
                afterAck <= AF_CMD;
                cmdSeen  <= 1'b1;
              end
            end
          end
          ST_ACKWAIT: if (busEv.sclFall) state <= ST_ACKHOLD;
          ST_ACKHOLD: if (busEv.sclFall) begin
            if (pendStop) begin
              pendStop <= 1'b0;
              cmdSeen  <= 1'b0;
              if (convActive) begin
                convStop   <= 1'b1;
                convActive <= 1'b0;
              end
            end
            unique case (afterAck)
              AF_CMD: begin
                state  <= ST_CMD;
                bitCnt <= '0;
                if (lastWasCmd && ackDrv && hsMode) stretchArm <= 1'b1;
              end
              AF_TX: begin
                state    <= ST_TXBIT;
                bitCnt   <= '0;
                isLoByte <= 1'b0;
              end
              default: state <= ST_IGNORE;
            endcase
          end
          ST_TXBIT: if (busEv.sclFall) begin
            if (bitCnt == LAST_BIT) state <= ST_MACK;
            else bitCnt <= bitCnt + 3'd1;
          end
          ST_MACK: if (busEv.sclRise) begin
            mAck  <= ~busEv.sda;
            state <= ST_MACKEND;
            if (isLoByte) popStrobe <= 1'b1;
          end
          ST_MACKEND: if (busEv.sclFall) begin
            if (mAck) begin
              state    <= ST_TXBIT;
              bitCnt   <= '0;
              isLoByte <= ~isLoByte;
            end else begin
              state <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_i2c_cmd_slave.sv
module adc_i2c_cmd_slave
  import adc_i2c_pkg::*;
#(
  parameter int         DATA_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] PREFIX      = 5'b10010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapIn,
  input  logic              holdReq,
  input  logic [DATA_W-1:0] rdData,
  output logic              sclOeN,
  output logic              sdaOeN,
  output logic              hsMode,
  output logic              convStart,
  output logic              convStop,
  output logic              stackClear,
  output logic              popStrobe
);
  busEv_t            busEv;
  txCtl_t            txCtl;
  logic [BYTE_W-1:0] rxNext;
  logic              txBit;

  adc_i2c_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rdData(rdData),
    .txCtl(txCtl), .busEv(busEv), .rxNext(rxNext), .txBit(txBit)
  );

  adc_i2c_ctrl #(.PREFIX(PREFIX)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .holdReq(holdReq),
    .busEv(busEv), .rxNext(rxNext), .txBit(txBit), .txCtl(txCtl),
    .sdaOeN(sdaOeN), .sclOeN(sclOeN), .hsMode(hsMode),
    .convStart(convStart), .convStop(convStop), .stackClear(stackClear),
    .popStrobe(popStrobe)
  );
endmodule

// File: rtl/adc_i2c_cmd_slave_chk.sv
module adc_i2c_cmd_slave_chk (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic convStop,
  input logic stackClear,
  input logic popStrobe,
  input logic hsMode,
  input logic sclOeN,
  input logic sdaOeN,
  input logic stopEv
);
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(convStart && convStop));                                        // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);                                        // R4
  AST_CLEAR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    stackClear |-> !convStart);                                       // R5
  AST_POP_SDA_FREE: assert property (@(posedge clk) disable iff (!rstN)
    popStrobe |-> sdaOeN);                                            // R7
  AST_HS_EXIT_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsMode) |-> $past(stopEv));                                 // R10
  AST_HS_ENTRY_NACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> sdaOeN);                                        // R11
  AST_STRETCH_HS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !sclOeN |-> hsMode);                                              // R12
endmodule

bind adc_i2c_cmd_slave adc_i2c_cmd_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .convStop(convStop),
  .stackClear(stackClear), .popStrobe(popStrobe), .hsMode(hsMode),
  .sclOeN(sclOeN), .sdaOeN(sdaOeN), .stopEv(busEv.stopCond)
);

// File: tb/adc_i2c_cmd_slave_bench.sv
module adc_i2c_cmd_slave_bench;
  localparam int Q = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, holdReq = 1'b0;
  logic [1:0] strapIn = 2'd0;
  logic sclOeN, sdaOeN, hsMode, convStart, convStop, stackClear, popStrobe;
  wire sclBus = sclM & sclOeN;
  wire sdaBus = sdaM & sdaOeN;

  logic [11:0] words [4];
  int nStart = 0, nStop = 0, nClr = 0, nPop = 0, snapStart = 0;
  int nChk = 0, nFail = 0;
  logic [11:0] rdData;
  assign rdData = words[nPop % 4];

  adc_i2c_cmd_slave u_adc_i2c_cmd_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .strapIn(strapIn),
    .holdReq(holdReq), .rdData(rdData), .sclOeN(sclOeN), .sdaOeN(sdaOeN),
    .hsMode(hsMode), .convStart(convStart), .convStop(convStop),
    .stackClear(stackClear), .popStrobe(popStrobe)
  );

  always @(posedge clk) begin
    if (convStart)  nStart <= nStart + 1;
    if (convStop)   nStop  <= nStop + 1;
    if (stackClear) nClr   <= nClr + 1;
    if (popStrobe)  nPop   <= nPop + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bitClk(input logic v, output logic s);
    sdaM = v; tick(Q);
    sclM = 1'b1; tick(1);
    while (!sclBus) tick(1);
    tick(2*Q);
    s = sdaBus;
    sclM = 1'b0; tick(Q);
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitClk(b[i], s);
      if (i == 5) snapStart = nStart;
    end
    bitClk(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitClk(1'b1, s);
      b[i] = s;
    end
    bitClk(~ackIt, s);
  endtask

  task automatic doReset(input logic [1:0] st);
    rstN = 1'b0; strapIn = st; sclM = 1'b1; sdaM = 1'b1; holdReq = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(3);
    strapIn = ~st;  // later strap changes must not matter (R2)
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic ack, ack2, s;
    logic [7:0] hi, lo;
    logic [11:0] exp;
    int s0, c0, p0, pp;
    for (int i = 0; i < 4; i++) words[i] = 12'((i * 1234 + 291) ^ 12'hA5C);

    // R13 reset state
    doReset(2'd2);
    chk("R13 sdaOeN", int'(sdaOeN), 1);
    chk("R13 sclOeN", int'(sclOeN), 1);
    chk("R13 hsMode", int'(hsMode), 0);
    chk("R13 strobes", nStart + nStop + nClr + nPop, 0);

    // R1/R2 address sweep over all strap settings
    for (int st = 0; st < 4; st++) begin
      doReset(2'(st));
      for (int a = 0; a < 4; a++) begin
        startC();
        sendByte({5'b10010, 2'(a), 1'b0}, ack);
        stopC();
        chk((a == st) ? "R2 strap kept R1 match" : "R1 strap mismatch", int'(ack), int'(a == st));
      end
      for (int pb = 0; pb < 5; pb++) begin
        startC();
        sendByte({5'b10010 ^ 5'(1 << pb), 2'(st), 1'b0}, ack);
        stopC();
        chk("R1 prefix mismatch", int'(ack), 0);
      end
    end

    // R3/R4/R5/R10 command sweep
    doReset(2'd1);
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 4; j++) begin
        s0 = nStart; c0 = nClr; p0 = nStop;
        startC();
        sendByte(8'b1001_0010, ack);
        sendByte({3'(k), 5'(j * 9)}, ack2);
        chk("R4 start before byte end", snapStart - s0, int'(k == 0));
        chk(k == 0 ? "R3 valid ack" : "R5 invalid nack", int'(ack2), int'(k == 0));
        chk("R5 stack clear", nClr - c0, int'(k != 0));
        stopC();
        chk("R10 stop ends conversion", nStop - p0, int'(k == 0));
        chk("R5 no start on invalid", nStart - s0, int'(k == 0));
      end
    end

    // R6 second consecutive valid command
    s0 = nStart; p0 = nStop;
    startC();
    sendByte(8'b1001_0010, ack);
    sendByte(8'h03, ack);
    chk("R3 first cmd ack", int'(ack), 1);
    sendByte(8'h1F, ack2);
    tick(2);
    chk("R6 second cmd nack", int'(ack2), 0);
    chk("R6 stop after nack", nStop - p0, 1);
    chk("R6 single start", nStart - s0, 1);
    stopC();
    chk("R6 no extra stop", nStop - p0, 1);

    // R7/R8/R9 four-word read
    p0 = nStop; pp = nPop;
    startC();
    sendByte(8'b1001_0010, ack);
    sendByte(8'h00, ack);
    startC();
    sendByte(8'b1001_0011, ack);
    chk("R1 read addr ack", int'(ack), 1);
    chk("R9 read addr ends conversion", nStop - p0, 1);
    for (int w = 0; w < 4; w++) begin
      exp = words[(pp + w) % 4];
      readByte(1'b1, hi);
      readByte(w != 3, lo);
      chk("R7 high byte", int'(hi), int'({4'b0000, exp[11:8]}));
      chk("R7 low byte", int'(lo), int'(exp[7:0]));
    end
    chk("R7 pop count", nPop - pp, 4);
    bitClk(1'b1, s);
    chk("R8 released after nack", int'(s), 1);
    chk("R8 sdaOeN", int'(sdaOeN), 1);
    stopC();
    chk("R10 no stop without conversion", nStop - p0, 1);

    // R11/R12 high-speed sequence
    startC();
    sendByte(8'h0D, ack);
    chk("R11 master code nack", int'(ack), 0);
    chk("R11 hs entered", int'(hsMode), 1);
    holdReq = 1'b1;
    startC();
    chk("R11 hs through restart", int'(hsMode), 1);
    sendByte(8'b1001_0010, ack);
    sendByte(8'h00, ack2);
    chk("R3 hs cmd ack", int'(ack2), 1);
    sclM = 1'b1; tick(8);
    chk("R12 scl stretched", int'(sclBus), 0);
    holdReq = 1'b0; tick(4);
    chk("R12 scl released", int'(sclBus), 1);
    sclM = 1'b0; tick(Q);
    startC();
    pp = nPop;
    exp = words[pp % 4];
    sendByte(8'b1001_0011, ack);
    readByte(1'b1, hi);
    readByte(1'b0, lo);
    chk("R7 hs word", int'({hi[3:0], lo}), int'(exp));
    stopC();
    chk("R10 hs cleared by stop", int'(hsMode), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule